// File: doc/BRIEF.md
# Self-Shrinking LFSR Keystream Generator

This block produces a stream of pseudo-random bytes for a block cipher that needs keyed control values. Its state is a 128-bit shift register in Galois form, stepped two positions per cycle. Each pair of raw output bits passes through a self-shrinking decimator: the second bit of the pair is kept only when the first bit is 1. Eight kept bits form one output byte. The byte is presented with a valid flag and held until the consumer takes it. While a byte waits, the generator stops stepping.

The secret key is loaded once at the start of a session. After the cipher has recovered each plaintext block, the block is XORed into the state through a feedback port, one byte lane onto the matching state lane. From then on every later output depends on all earlier blocks. Only a fresh key load restores a known state. A running count of taken bytes lets the cipher track its position: one block uses 64 bytes. An all-zero state is never allowed, because the register would then produce zeros forever.

Top module: `ssg_keystream_gen`

## Requirements
- R1: After reset, and until the first key load, `rnd_valid` is 0, `take_count` is 0 and no byte is produced.
- R2: A pulse on `key_load` sets the state to `key_in`. If `key_in` is all zero, the state becomes 1 instead (bit 0 forced to 1). The load clears `rnd_valid`, any partly assembled byte and `take_count`. It has priority over `take` and `fb_en` in the same cycle.
- R3: One LFSR step shifts the 128-bit state right by one position. The bit that leaves position 0 is the raw output bit. When that bit is 1, bits 127, 126, 125 and 120 of the shifted value are inverted.
- R4: Each generating cycle performs two steps. If the first raw bit is 1, the second raw bit is kept. If the first raw bit is 0, both bits are dropped.
- R5: Kept bits fill the output byte MSB first. The first kept bit becomes bit 7. After the eighth kept bit, the byte appears on `rnd_byte` with `rnd_valid` high.
- R6: While `rnd_valid` is high and no `take` or `key_load` arrives, `rnd_byte` stays constant and the state does not step. After a delay of any length, the next byte is therefore the same as it would be with an immediate take.
- R7: `take` while `rnd_valid` is high clears `rnd_valid` at the next edge and increments `take_count`. `take` while `rnd_valid` is low has no effect on the count.
- R8: `fb_en` while `rnd_valid` is low and a key is loaded applies the feedback in one cycle. The state becomes state XOR `fb_block`, with byte i (bits 8i+7:8i) going into state byte i. If that result is zero, bit 0 is forced to 1. That cycle performs no step, and any partly assembled byte is discarded.
- R9: `fb_en` while `rnd_valid` is high is ignored. The pending byte and all later bytes are unchanged.
- R10: Neither taking bytes nor feedback ever reloads the state. A sequence of many blocks with feedback between them follows a single chain that starts from the one key load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_load | input | 1 | Load `key_in` into the state |
| key_in | input | 128 | Secret key |
| fb_en | input | 1 | Apply plaintext feedback |
| fb_block | input | 128 | Plaintext block; byte i goes onto state byte i |
| take | input | 1 | Consumer takes the presented byte |
| rnd_byte | output | 8 | Presented random byte |
| rnd_valid | output | 1 | `rnd_byte` holds an untaken byte |
| take_count | output | 16 | Bytes taken since the last key load |

## Verification
The assertions check on every cycle the following properties:
- the presented byte holds while it waits, and the state stays frozen when nothing drives it;
- the state never reaches zero;
- the count advances once per accepted take;
- no byte appears before a key.

Only the bench scenarios can show the keystream values themselves. These include:
- the tap positions, the pair rule and the MSB-first order;
- the zero-key substitution;
- that feedback lands on the right lanes and discards a partial byte;
- that a feedback request during a valid byte leaves the whole later stream unchanged.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

  // Raw bit pair produced by two LFSR steps in one cycle
  typedef struct packed {
    logic lead;   // first raw bit: decides keep or drop
    logic trail;  // second raw bit: the candidate output bit
  } ssg_pair_t;

  // True when 0-based bit position pos corresponds to a 1-based tap
  function automatic bit is_tap(input int pos, input int ta, input int tb,
                                input int tc, input int td);
    return (pos == ta - 1) || (pos == tb - 1) || (pos == tc - 1) || (pos == td - 1);
  endfunction

endpackage

// File: rtl/ssg_lfsr_core.sv
module ssg_lfsr_core import ssg_pkg::*; #(
  parameter int STATE_W = 128,
  parameter int TAP_A   = 128,
  parameter int TAP_B   = 127,
  parameter int TAP_C   = 126,
  parameter int TAP_D   = 121
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [STATE_W-1:0] key,
  input  logic               fb_hit,
  input  logic [STATE_W-1:0] fb_blk,
  input  logic               advance,
  output ssg_pair_t          pair
);

  localparam int NLANES = STATE_W / 8;

  function automatic logic [STATE_W-1:0] build_mask();
    logic [STATE_W-1:0] m;
    m = '0;
    for (int i = 0; i < STATE_W; i++)
      if (is_tap(i, TAP_A, TAP_B, TAP_C, TAP_D)) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [STATE_W-1:0] TAP_MASK = build_mask();

  function automatic logic [STATE_W-1:0] galois_step(input logic [STATE_W-1:0] s);
    return {1'b0, s[STATE_W-1:1]} ^ (s[0] ? TAP_MASK : '0);
  endfunction

  logic [STATE_W-1:0] st, mid, nxt, mixed, key_safe, mixed_safe;

  assign mid = galois_step(st);
  assign nxt = galois_step(mid);
  assign pair.lead  = st[0];
  assign pair.trail = mid[0];

  // Plaintext feedback: one lane per byte
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign mixed[8*g +: 8] = st[8*g +: 8] ^ fb_blk[8*g +: 8];
  end

  assign key_safe   = key   | {{(STATE_W-1){1'b0}}, (key   == '0)};
  assign mixed_safe = mixed | {{(STATE_W-1){1'b0}}, (mixed == '0)};

  always_ff @(posedge clk) begin
    if (rst)          st <= {{(STATE_W-1){1'b0}}, 1'b1};
    else if (load)    st <= key_safe;
    else if (fb_hit)  st <= mixed_safe;
    else if (advance) st <= nxt;
  end

  AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (rst)
    st != '0); // R2

  AST_STATE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!load && !fb_hit && !advance) |=> $stable(st)); // R6

endmodule

// File: rtl/ssg_byte_pack.sv
module ssg_byte_pack import ssg_pkg::*; #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              advance,
  input  ssg_pair_t         pair,
  input  logic              take,
  output logic [BYTE_W-1:0] byte_q,
  output logic              valid_q
);

  localparam int CW = $clog2(BYTE_W);

  logic [BYTE_W-1:0] acc;
  logic [CW-1:0]     kept;
  logic [BYTE_W-1:0] acc_next;

  assign acc_next = {acc[BYTE_W-2:0], pair.trail};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc     <= '0;
      kept    <= '0;
      valid_q <= 1'b0;
      if (rst) byte_q <= '0;
    end else begin
      if (valid_q && take) valid_q <= 1'b0;
      if (advance && pair.lead) begin
        acc <= acc_next;
        if (kept == CW'(BYTE_W - 1)) begin
          byte_q  <= acc_next;
          valid_q <= 1'b1;
          kept    <= '0;
        end else begin
          kept <= kept + 1'b1;
        end
      end
    end
  end

  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !take && !clear) |=> (valid_q && $stable(byte_q))); // R6

  AST_NO_STEP_WHILE_VALID: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> !advance); // R6

  AST_TAKE_DROPS: assert property (@(posedge clk) disable iff (rst)
    (valid_q && take) |=> !valid_q); // R7

endmodule

// File: rtl/ssg_keystream_gen.sv
module ssg_keystream_gen import ssg_pkg::*; #(
  parameter int STATE_W = 128,
  parameter int BYTE_W  = 8,
  parameter int CNT_W   = 16,
  parameter int TAP_A   = 128,
  parameter int TAP_B   = 127,
  parameter int TAP_C   = 126,
  parameter int TAP_D   = 121
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               key_load,
  input  logic [STATE_W-1:0] key_in,
  input  logic               fb_en,
  input  logic [STATE_W-1:0] fb_block,
  input  logic               take,
  output logic [BYTE_W-1:0]  rnd_byte,
  output logic               rnd_valid,
  output logic [CNT_W-1:0]   take_count
);

  logic      keyed;
  logic      fb_hit, take_hit, advance, clear;
  ssg_pair_t pair;

  assign fb_hit   = fb_en && keyed && !rnd_valid && !key_load;
  assign take_hit = take && rnd_valid && !key_load;
  assign clear    = key_load || fb_hit;
  assign advance  = keyed && !rnd_valid && !clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      keyed      <= 1'b0;
      take_count <= '0;
    end else if (key_load) begin
      keyed      <= 1'b1;
      take_count <= '0;
    end else if (take_hit) begin
      take_count <= take_count + 1'b1;
    end
  end

  ssg_lfsr_core #(
    .STATE_W(STATE_W), .TAP_A(TAP_A), .TAP_B(TAP_B), .TAP_C(TAP_C), .TAP_D(TAP_D)
  ) u_core (
    .clk(clk), .rst(rst), .load(key_load), .key(key_in),
    .fb_hit(fb_hit), .fb_blk(fb_block), .advance(advance), .pair(pair)
  );

  ssg_byte_pack #(.BYTE_W(BYTE_W)) u_pack (
    .clk(clk), .rst(rst), .clear(clear), .advance(advance), .pair(pair),
    .take(take_hit), .byte_q(rnd_byte), .valid_q(rnd_valid)
  );

  AST_IDLE_UNKEYED: assert property (@(posedge clk) disable iff (rst)
    !keyed |-> (!rnd_valid && take_count == '0)); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    take_hit |=> (take_count == $past(take_count) + 1'b1)); // R7

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    key_load |=> (!rnd_valid && take_count == '0)); // R2

  AST_FB_IGNORED_VALID: assert property (@(posedge clk) disable iff (rst)
    (fb_en && rnd_valid && !take && !key_load) |=> (rnd_valid && $stable(rnd_byte))); // R9

endmodule

// File: tb/tb_ssg_keystream_gen.sv
module tb_ssg_keystream_gen;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst, key_load, fb_en, take;
  logic [127:0] key_in, fb_block;
  logic [7:0]   rnd_byte;
  logic         rnd_valid;
  logic [15:0]  take_count;

  int vectors = 0, errors = 0;
  bit done = 0;
  logic [127:0] m_st;     // bench reference state
  int           m_count;  // bench expected take count

  always #(CLK_PERIOD/2) clk = ~clk;

  ssg_keystream_gen dut (
    .clk(clk), .rst(rst), .key_load(key_load), .key_in(key_in), .fb_en(fb_en),
    .fb_block(fb_block), .take(take), .rnd_byte(rnd_byte), .rnd_valid(rnd_valid),
    .take_count(take_count)
  );

  // ---- reference model written from the requirements ----
  function automatic logic [127:0] ref_shift(input logic [127:0] s);
    logic o;
    o = s[0];
    s = s >> 1;
    if (o) begin
      s[127] = ~s[127]; s[126] = ~s[126]; s[125] = ~s[125]; s[120] = ~s[120];
    end
    return s;
  endfunction

  task automatic ref_pair(output logic keep, output logic b);
    logic a;
    a = m_st[0]; m_st = ref_shift(m_st);
    b = m_st[0]; m_st = ref_shift(m_st);
    keep = a;
  endtask

  task automatic ref_byte(output logic [7:0] r);
    int n = 0;
    logic k, b;
    r = 8'h00;
    while (n < 8) begin
      ref_pair(k, b);
      if (k) begin r[7-n] = b; n++; end
    end
  endtask

  task automatic ref_fb(input logic [127:0] p);
    for (int i = 0; i < 16; i++) m_st[8*i +: 8] = m_st[8*i +: 8] ^ p[8*i +: 8];
    if (m_st == 128'd0) m_st = 128'd1;
  endtask

  // ---- checking helpers ----
  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_valid(input string req);
    for (int n = 0; n < 4000 && !rnd_valid; n++) @(negedge clk);
    chk(req, 32'(rnd_valid), 32'd1);
  endtask

  task automatic do_take();
    take = 1'b1; @(negedge clk); take = 1'b0;
  endtask

  // compare next byte to model, then take it
  task automatic get_byte(input string req);
    logic [7:0] e;
    ref_byte(e);
    wait_valid(req);
    chk(req, 32'(rnd_byte), 32'(e));
    do_take();
    m_count++;
  endtask

  task automatic load_key(input logic [127:0] k);
    key_in = k; key_load = 1'b1; @(negedge clk); key_load = 1'b0;
    m_st = (k == 128'd0) ? 128'd1 : k;
    m_count = 0;
  endtask

  task automatic apply_fb(input logic [127:0] p);
    fb_block = p; fb_en = 1'b1; @(negedge clk); fb_en = 1'b0;
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    repeat (20) @(negedge clk);
    chk("R1 valid after reset", 32'(rnd_valid), 32'd0);
    chk("R1 count after reset", 32'(take_count), 32'd0);
  endtask

  task automatic t_basic();
    load_key(128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210);
    chk("R2 valid cleared by load", 32'(rnd_valid), 32'd0);
    for (int i = 0; i < 8; i++) get_byte("R3 R4 R5 stream byte");
    chk("R7 count after 8 takes", 32'(take_count), 32'd8);
  endtask

  task automatic t_hold();
    logic [7:0] e, first;
    ref_byte(e);
    wait_valid("R6 wait");
    first = rnd_byte;
    repeat (12) @(negedge clk);
    chk("R6 still valid", 32'(rnd_valid), 32'd1);
    chk("R6 byte held", 32'(rnd_byte), 32'(first));
    chk("R6 held byte value", 32'(rnd_byte), 32'(e));
    do_take(); m_count++;
    get_byte("R6 byte after long hold");
  endtask

  task automatic t_take_idle();
    do_take();   // rnd_valid low here: ignored
    chk("R7 idle take ignored", 32'(take_count), 32'(m_count));
    get_byte("R7 stream after idle take");
    chk("R7 count", 32'(take_count), 32'(m_count));
  endtask

  task automatic t_feedback();
    logic k, b;
    logic [127:0] p = 128'h00ff_1122_3344_5566_7788_99aa_bbcc_ddee;
    apply_fb(p); ref_fb(p);
    get_byte("R8 byte after feedback");
    get_byte("R8 second byte after feedback");
    // partial byte: 3 generating cycles, then feedback discards their bits
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) ref_pair(k, b);
    p = 128'h8000_0000_0000_0000_0000_0000_0000_0001;
    apply_fb(p); ref_fb(p);
    get_byte("R8 partial byte discarded");
  endtask

  task automatic t_fb_ignored();
    logic [7:0] e, first;
    ref_byte(e);
    wait_valid("R9 wait");
    first = rnd_byte;
    apply_fb(128'hdead_beef_dead_beef_dead_beef_dead_beef);
    chk("R9 valid kept", 32'(rnd_valid), 32'd1);
    chk("R9 byte unchanged", 32'(rnd_byte), 32'(first));
    chk("R9 byte value", 32'(rnd_byte), 32'(e));
    do_take(); m_count++;
    get_byte("R9 later stream unaffected");
  endtask

  task automatic t_zero_key();
    load_key(128'd0);
    chk("R2 zero-key count cleared", 32'(take_count), 32'd0);
    for (int i = 0; i < 4; i++) get_byte("R2 zero key stream");
  endtask

  task automatic t_session();
    logic [127:0] blk;
    load_key(128'h5a5a_0f0f_c3c3_9696_1234_5678_9abc_def0);
    for (int b = 0; b < 3; b++) begin
      for (int i = 0; i < 64; i++) get_byte("R10 chained block byte");
      blk = {4{32'h1357_9bdf + 32'(b)}};
      apply_fb(blk); ref_fb(blk);
    end
    chk("R10 count across blocks", 32'(take_count), 32'd192);
    // reload during a pending byte
    wait_valid("R2 wait before reload");
    take = 1'b1;
    load_key(128'h1);     // load wins over take
    take = 1'b0;
    chk("R2 reload clears valid", 32'(rnd_valid), 32'd0);
    chk("R2 reload clears count", 32'(take_count), 32'd0);
    get_byte("R2 stream after reload");
  endtask

  initial begin
    rst = 1'b1; key_load = 0; fb_en = 0; take = 0; key_in = '0; fb_block = '0;
    m_st = 128'd1; m_count = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_hold();
    t_take_idle();
    t_feedback();
    t_fb_ignored();
    t_zero_key();
    t_session();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule